// File: doc/BRIEF.md
# Auxiliary system control registers

This block gathers the small control and status registers of a workstation I/O chip behind one synchronous register port. Most of the registers hold plain values: configuration, diagnostics, modem control and a 16-bit LED pattern. Others act on the rest of the system. One register fires a one-cycle terminal-count strobe toward a floppy controller. Another holds a power-fail flag that raises an interrupt and can be cleared by software, and also holds the software power-down request. A system-control word latches a reset-status code and requests a system reset.

Each access is one cycle long. The requester drives `req_valid` with an address, a size code, a direction and write data. Read data appears on `rsp_rdata` one cycle after the read strobe and holds until the next read. Every register sits on the low byte lanes of the data bus. Each register accepts one access size only. An access of any other size, or to an unmapped address, does nothing and reads as zero.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Address map with size codes (0 = byte, 1 = 16-bit, 2 = 32-bit). Configuration is at 0x00, diagnostic at 0x01, modem control at 0x02, auxiliary 1 at 0x03 and auxiliary 2 at 0x04, each byte-sized. The LED register is at 0x08, 16-bit. System control is at 0x10, 32-bit. A read returns the zero-extended register on `rsp_rdata` in the cycle after the strobe.
- R2: An access with the wrong size code, or to an unmapped address, changes nothing and causes no pulse or request. Such a read returns zero.
- R3: `irq_o` is high exactly when the power-fail flag (auxiliary 2 bit 5) and the interrupt enable (configuration bit 3) are both set.
- R4: On every change of `pwr_fail_i`, the flag is loaded with the new input level ANDed with configuration bit 3. The change takes effect at the next clock edge.
- R5: A write to auxiliary 2 stores only bits 0 and 1 of the write data. The current flag is kept in bit 5.
- R6: When an auxiliary 2 write has bit 1 set, the stored value keeps only bit 0. The flag and bit 1 both read back as zero, and `irq_o` falls.
- R7: When a write to auxiliary 2 leaves bit 0 set, `pwroff_req_o` rises and stays high until reset, whatever is written later.
- R8: An auxiliary 1 write with bit 1 set makes `tc_pulse_o` high for exactly the one cycle after the write. Bit 1 is never stored. The other bits are stored as written.
- R9: A 32-bit write at 0x10 with bit 0 set makes system control read 0x02 and raises `sysrst_req_o`, which stays high until reset. A write with bit 0 clear changes nothing. A 32-bit read at 0x11 to 0x13 returns zero.
- R10: Reset clears configuration, modem control, auxiliary 1, auxiliary 2, the flag and both requests. Diagnostic and system-control contents survive reset.
- R11: A read changes no register. Reading auxiliary 2 repeatedly returns the same flag.
- R12: The LED register stores and returns all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 byte, 1 16-bit, 2 32-bit |
| req_wdata | input | 32 | Write data, low lanes |
| rsp_rdata | output | 32 | Registered read data |
| pwr_fail_i | input | 1 | Power-fail indication, synchronous |
| irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | Terminal-count strobe |
| pwroff_req_o | output | 1 | Sticky power-off request |
| sysrst_req_o | output | 1 | Sticky system-reset request |

## Verification
The hardest states to reach are those where the power-fail flag disagrees with the interrupt. One is a flag that stays set after the enable has been cleared. Another is a flag that stays clear while the input is high, because the enable was off when the input changed. The bench reaches both by ordering configuration writes around input edges. It then reads auxiliary 2 and watches `irq_o`, without any internal probe. The survival of diagnostic and system-control contents across reset is checked by writing them first, then pulsing reset, then reading them back.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int MAP_ADDR_W = 5;
  localparam int NUM_BYTE_REGS = 5;

  localparam logic [MAP_ADDR_W-1:0] ADR_CFG   = 5'h00;
  localparam logic [MAP_ADDR_W-1:0] ADR_DIAG  = 5'h01;
  localparam logic [MAP_ADDR_W-1:0] ADR_MODEM = 5'h02;
  localparam logic [MAP_ADDR_W-1:0] ADR_AUX1  = 5'h03;
  localparam logic [MAP_ADDR_W-1:0] ADR_AUX2  = 5'h04;
  localparam logic [MAP_ADDR_W-1:0] ADR_LED   = 5'h08;
  localparam logic [MAP_ADDR_W-1:0] ADR_SYS   = 5'h10;

  localparam int CFG_IRQEN_BIT = 3;
  localparam int AUX1_TC_BIT   = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_FLAG_BIT = 5;
  localparam int SYS_GO_BIT    = 0;
  localparam logic [7:0] SYS_STAT_CODE = 8'h02;

  typedef struct packed {
    logic cfg;
    logic diag;
    logic modem;
    logic aux1;
    logic aux2;
    logic led;
    logic sys;
  } reg_hit_t;

  // address of the i-th byte-wide register
  function automatic logic [MAP_ADDR_W-1:0] byte_reg_addr(input int idx);
    case (idx)
      0:       return ADR_CFG;
      1:       return ADR_DIAG;
      2:       return ADR_MODEM;
      3:       return ADR_AUX1;
      default: return ADR_AUX2;
    endcase
  endfunction

  // stored value of auxiliary 2 after a write
  function automatic logic [7:0] aux2_after_write(input logic [7:0] wr, input logic [7:0] cur);
    logic [7:0] v;
    v = 8'h00;
    v[AUX2_OFF_BIT]  = wr[AUX2_OFF_BIT];
    v[AUX2_CLR_BIT]  = wr[AUX2_CLR_BIT];
    v[AUX2_FLAG_BIT] = cur[AUX2_FLAG_BIT];
    if (v[AUX2_CLR_BIT]) begin
      v = 8'h00;
      v[AUX2_OFF_BIT] = wr[AUX2_OFF_BIT];
    end
    return v;
  endfunction

  // auxiliary 1 never keeps the strobe bit
  function automatic logic [7:0] aux1_after_write(input logic [7:0] wr);
    logic [7:0] v;
    v = wr;
    v[AUX1_TC_BIT] = 1'b0;
    return v;
  endfunction

  // flag value taken on a power-fail input change
  function automatic logic flag_on_change(input logic level, input logic enable);
    return level & enable;
  endfunction

endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode
  import aux_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_hit_t          wr_hit,
  output reg_hit_t          rd_hit,
  output logic              rd_stb,
  output logic              size_bad
);

  logic [NUM_BYTE_REGS-1:0] byte_at;
  logic [NUM_BYTE_REGS-1:0] byte_ok;
  logic led_at, sys_at, led_ok, sys_ok;
  reg_hit_t hit;

  for (genvar gi = 0; gi < NUM_BYTE_REGS; gi++) begin : g_byte
    assign byte_at[gi] = (req_addr == ADDR_W'(byte_reg_addr(gi)));
    assign byte_ok[gi] = byte_at[gi] && (req_size == SZ_BYTE);
  end

  assign led_at = (req_addr == ADDR_W'(ADR_LED));
  assign sys_at = (req_addr == ADDR_W'(ADR_SYS));
  assign led_ok = led_at && (req_size == SZ_HALF);
  assign sys_ok = sys_at && (req_size == SZ_WORD);

  always_comb begin
    hit       = '0;
    hit.cfg   = byte_ok[0];
    hit.diag  = byte_ok[1];
    hit.modem = byte_ok[2];
    hit.aux1  = byte_ok[3];
    hit.aux2  = byte_ok[4];
    hit.led   = led_ok;
    hit.sys   = sys_ok;
  end

  assign wr_hit   = (req_valid && req_write)  ? hit : '0;
  assign rd_hit   = (req_valid && !req_write) ? hit : '0;
  assign rd_stb   = req_valid && !req_write;
  assign size_bad = req_valid && (|byte_at || led_at || sys_at) && (hit == '0);

endmodule

// File: rtl/aux_power_ctl.sv
module aux_power_ctl
  import aux_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       aux2_wr,
  input  logic [7:0] wdata,
  input  logic       pwr_fail_i,
  output logic [7:0] cfg_q,
  output logic [7:0] aux2_q,
  output logic       irq_o,
  output logic       pwroff_o
);

  logic       pf_prev;
  logic       pf_changed;
  logic [7:0] aux2_wr_val;
  logic [7:0] aux2_d;
  logic [7:0] cfg_d;

  assign pf_changed  = (pwr_fail_i != pf_prev);
  assign aux2_wr_val = aux2_after_write(wdata, aux2_q);
  assign cfg_d       = cfg_wr ? wdata : cfg_q;

  always_comb begin
    aux2_d = aux2_wr ? aux2_wr_val : aux2_q;
    if (pf_changed) aux2_d[AUX2_FLAG_BIT] = flag_on_change(pwr_fail_i, cfg_q[CFG_IRQEN_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      aux2_q   <= '0;
      pf_prev  <= 1'b0;
      pwroff_o <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      aux2_q  <= aux2_d;
      pf_prev <= pwr_fail_i;
      if (aux2_wr && aux2_wr_val[AUX2_OFF_BIT]) pwroff_o <= 1'b1;
    end
  end

  assign irq_o = aux2_q[AUX2_FLAG_BIT] && cfg_q[CFG_IRQEN_BIT];

  AST_IRQ_DROPS_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !wdata[CFG_IRQEN_BIT]) |=> !irq_o); // R3
  AST_FLAG_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux2_q[AUX2_FLAG_BIT]) |-> $past(pwr_fail_i && cfg_q[CFG_IRQEN_BIT])); // R4
  AST_CLEAR_KILLS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_wr && wdata[AUX2_CLR_BIT] && !pf_changed) |=> (!aux2_q[AUX2_FLAG_BIT] && !irq_o)); // R6
  AST_PWROFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pwroff_o)); // R7

endmodule

// File: rtl/aux_misc_regs.sv
module aux_misc_regs
  import aux_regs_pkg::*;
#(
  parameter int LED_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diag_wr,
  input  logic             modem_wr,
  input  logic             aux1_wr,
  input  logic             led_wr,
  input  logic             sys_wr,
  input  logic [LED_W-1:0] wdata,
  output logic [7:0]       diag_q,
  output logic [7:0]       modem_q,
  output logic [7:0]       aux1_q,
  output logic [LED_W-1:0] led_q,
  output logic [7:0]       sys_q,
  output logic             tc_pulse_o,
  output logic             sysrst_o
);

  logic tc_fire;
  logic sys_go;

  assign tc_fire = aux1_wr && wdata[AUX1_TC_BIT];
  assign sys_go  = sys_wr && wdata[SYS_GO_BIT];

  // diagnostic and system-control contents survive block reset
  always_ff @(posedge clk) begin
    if (diag_wr) diag_q <= wdata[7:0];
    if (sys_go)  sys_q  <= SYS_STAT_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modem_q    <= '0;
      aux1_q     <= '0;
      led_q      <= '0;
      tc_pulse_o <= 1'b0;
      sysrst_o   <= 1'b0;
    end else begin
      if (modem_wr) modem_q <= wdata[7:0];
      if (aux1_wr)  aux1_q  <= aux1_after_write(wdata[7:0]);
      if (led_wr)   led_q   <= wdata;
      tc_pulse_o <= tc_fire;
      if (sys_go) sysrst_o <= 1'b1;
    end
  end

  AST_TC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse_o |-> $past(aux1_wr && wdata[AUX1_TC_BIT])); // R8
  AST_SYSRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sysrst_o)); // R9
  AST_SYSRST_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysrst_o) |-> (sys_q == SYS_STAT_CODE)); // R9

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_regs_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  input  logic              pwr_fail_i,
  output logic              irq_o,
  output logic              tc_pulse_o,
  output logic              pwroff_req_o,
  output logic              sysrst_req_o
);

  localparam int DATA_W = 32;

  reg_hit_t          wr_hit, rd_hit;
  logic              rd_stb, size_bad;
  logic [7:0]        cfg_q, aux2_q, diag_q, modem_q, aux1_q, sys_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:LED_W];

  aux_bus_decode #(.ADDR_W(ADDR_W)) decode_i (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .rd_stb    (rd_stb),
    .size_bad  (size_bad)
  );

  aux_power_ctl power_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (wr_hit.cfg),
    .aux2_wr    (wr_hit.aux2),
    .wdata      (req_wdata[7:0]),
    .pwr_fail_i (pwr_fail_i),
    .cfg_q      (cfg_q),
    .aux2_q     (aux2_q),
    .irq_o      (irq_o),
    .pwroff_o   (pwroff_req_o)
  );

  aux_misc_regs #(.LED_W(LED_W)) misc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .diag_wr    (wr_hit.diag),
    .modem_wr   (wr_hit.modem),
    .aux1_wr    (wr_hit.aux1),
    .led_wr     (wr_hit.led),
    .sys_wr     (wr_hit.sys),
    .wdata      (req_wdata[LED_W-1:0]),
    .diag_q     (diag_q),
    .modem_q    (modem_q),
    .aux1_q     (aux1_q),
    .led_q      (led_q),
    .sys_q      (sys_q),
    .tc_pulse_o (tc_pulse_o),
    .sysrst_o   (sysrst_req_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      rd_hit.cfg:   rd_mux = DATA_W'(cfg_q);
      rd_hit.diag:  rd_mux = DATA_W'(diag_q);
      rd_hit.modem: rd_mux = DATA_W'(modem_q);
      rd_hit.aux1:  rd_mux = DATA_W'(aux1_q);
      rd_hit.aux2:  rd_mux = DATA_W'(aux2_q);
      rd_hit.led:   rd_mux = DATA_W'(led_q);
      rd_hit.sys:   rd_mux = DATA_W'(sys_q);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_rdata <= '0;
    else if (rd_stb) rsp_rdata <= rd_mux;
  end

  AST_BAD_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_bad && req_write) |=> !tc_pulse_o); // R2
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (size_bad && !req_write) |=> (rsp_rdata == '0)); // R2
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ($stable(cfg_q) && $stable(aux1_q) && $stable(modem_q))); // R11
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit) && $onehot0(rd_hit)); // R1

endmodule

// File: tb/aux_sysctl_regs_tb.sv
module aux_sysctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        pwr_fail_i = 1'b0;
  logic        irq_o, tc_pulse_o, pwroff_req_o, sysrst_req_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic tc_seen;
  logic [31:0] rd;

  always #4 clk = ~clk;

  aux_sysctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .pwr_fail_i(pwr_fail_i), .irq_o(irq_o),
    .tc_pulse_o(tc_pulse_o), .pwroff_req_o(pwroff_req_o), .sysrst_req_o(sysrst_req_o)
  );

  // {waddr, wsize, wdata, raddr, rsize, expected, requirement number}
  localparam int NV = 10;
  localparam logic [81:0] VEC [NV] = '{
    {5'h00, 2'd0, 32'h0000_00A5, 5'h00, 2'd0, 32'h0000_00A5, 4'd1},  // R1 cfg
    {5'h01, 2'd0, 32'h0000_003C, 5'h01, 2'd0, 32'h0000_003C, 4'd1},  // R1 diag
    {5'h02, 2'd0, 32'h0000_0081, 5'h02, 2'd0, 32'h0000_0081, 4'd1},  // R1 modem
    {5'h03, 2'd0, 32'h0000_00FF, 5'h03, 2'd0, 32'h0000_00FD, 4'd8},  // R8 strobe bit dropped
    {5'h04, 2'd0, 32'h0000_00FE, 5'h04, 2'd0, 32'h0000_0000, 4'd5},  // R5 only low bits, clear wins
    {5'h08, 2'd1, 32'h1234_BEEF, 5'h08, 2'd1, 32'h0000_BEEF, 4'd12}, // R12 led
    {5'h08, 2'd0, 32'h0000_0012, 5'h08, 2'd1, 32'h0000_BEEF, 4'd2},  // R2 byte write to led ignored
    {5'h00, 2'd2, 32'h0000_0000, 5'h00, 2'd0, 32'h0000_00A5, 4'd2},  // R2 word write to cfg ignored
    {5'h01, 2'd0, 32'h0000_003C, 5'h00, 2'd1, 32'h0000_0000, 4'd2},  // R2 wrong-size read is zero
    {5'h1F, 2'd0, 32'h0000_0055, 5'h1F, 2'd0, 32'h0000_0000, 4'd2}   // R2 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    tc_seen = tc_pulse_o;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic set_pf(input logic v);
    @(negedge clk);
    pwr_fail_i = v;
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", {31'd0, irq_o}, 32'd0);
    chk("R10 tc", {31'd0, tc_pulse_o}, 32'd0);
    chk("R10 pwroff", {31'd0, pwroff_req_o}, 32'd0);
    chk("R10 sysrst", {31'd0, sysrst_req_o}, 32'd0);
    bus_read(5'h00, 2'd0, rd); chk("R10 cfg", rd, 32'h0);
    bus_read(5'h04, 2'd0, rd); chk("R10 aux2", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      bus_write(v[81:77], v[76:75], v[74:43]);
      bus_read(v[42:38], v[37:36], rd);
      chk($sformatf("R%0d vector %0d", v[3:0], i), rd, v[35:4]);
    end

    // R4 / R3: enabled flag follows input change
    bus_write(5'h00, 2'd0, 32'h08);
    set_pf(1'b1);
    chk("R3 irq on", {31'd0, irq_o}, 32'd1);
    bus_read(5'h04, 2'd0, rd); chk("R4 flag set", rd, 32'h20);
    bus_read(5'h04, 2'd0, rd); chk("R11 reread flag", rd, 32'h20);
    bus_write(5'h04, 2'd0, 32'h00);
    bus_read(5'h04, 2'd0, rd); chk("R5 flag merged", rd, 32'h20);
    chk("R5 irq kept", {31'd0, irq_o}, 32'd1);
    bus_write(5'h00, 2'd0, 32'h00);
    chk("R3 irq off with enable clear", {31'd0, irq_o}, 32'd0);
    bus_read(5'h04, 2'd0, rd); chk("R3 flag still held", rd, 32'h20);
    bus_write(5'h00, 2'd0, 32'h08);
    chk("R3 irq back", {31'd0, irq_o}, 32'd1);
    bus_write(5'h04, 2'd0, 32'h02);
    chk("R6 irq cleared", {31'd0, irq_o}, 32'd0);
    bus_read(5'h04, 2'd0, rd); chk("R6 aux2 after clear", rd, 32'h00);
    set_pf(1'b0);
    bus_write(5'h00, 2'd0, 32'h00);
    set_pf(1'b1);
    bus_read(5'h04, 2'd0, rd); chk("R4 flag blocked by enable", rd, 32'h00);
    chk("R4 irq low", {31'd0, irq_o}, 32'd0);

    // R8 terminal count strobe
    bus_write(5'h03, 2'd0, 32'h02);
    chk("R8 strobe high", {31'd0, tc_seen}, 32'd1);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'd0, tc_pulse_o}, 32'd0);
    bus_read(5'h03, 2'd0, rd); chk("R8 bit not stored", rd, 32'h00);
    bus_write(5'h03, 2'd0, 32'h01);
    chk("R8 no strobe", {31'd0, tc_seen}, 32'd0);
    bus_write(5'h03, 2'd1, 32'h02);
    chk("R2 wrong-size aux1 no strobe", {31'd0, tc_seen}, 32'd0);

    // R7 power-off
    bus_write(5'h04, 2'd1, 32'h01);
    chk("R2 wrong-size aux2 no request", {31'd0, pwroff_req_o}, 32'd0);
    bus_write(5'h04, 2'd0, 32'h01);
    chk("R7 request", {31'd0, pwroff_req_o}, 32'd1);
    bus_read(5'h04, 2'd0, rd); chk("R7 aux2 bit0", rd, 32'h01);
    bus_write(5'h04, 2'd0, 32'h00);
    chk("R7 held", {31'd0, pwroff_req_o}, 32'd1);

    // R9 system control
    bus_write(5'h10, 2'd2, 32'hFFFF_FFFE);
    chk("R9 no go without bit0", {31'd0, sysrst_req_o}, 32'd0);
    bus_write(5'h10, 2'd0, 32'h01);
    chk("R2 byte write to sysctl", {31'd0, sysrst_req_o}, 32'd0);
    bus_write(5'h10, 2'd2, 32'h01);
    chk("R9 request", {31'd0, sysrst_req_o}, 32'd1);
    bus_read(5'h10, 2'd2, rd); chk("R9 status", rd, 32'h02);
    bus_read(5'h11, 2'd2, rd); chk("R9 other offset", rd, 32'h00);
    bus_write(5'h10, 2'd2, 32'h00);
    chk("R9 held", {31'd0, sysrst_req_o}, 32'd1);

    // R10 selective reset
    bus_write(5'h01, 2'd0, 32'h5A);
    bus_write(5'h02, 2'd0, 32'h77);
    bus_write(5'h00, 2'd0, 32'h08);
    set_pf(1'b0);
    pulse_reset();
    chk("R10 pwroff cleared", {31'd0, pwroff_req_o}, 32'd0);
    chk("R10 sysrst cleared", {31'd0, sysrst_req_o}, 32'd0);
    bus_read(5'h01, 2'd0, rd); chk("R10 diag kept", rd, 32'h5A);
    bus_read(5'h10, 2'd2, rd); chk("R10 sysctl kept", rd, 32'h02);
    bus_read(5'h02, 2'd0, rd); chk("R10 modem cleared", rd, 32'h00);
    bus_read(5'h00, 2'd0, rd); chk("R10 cfg cleared", rd, 32'h00);
    bus_read(5'h03, 2'd0, rd); chk("R10 aux1 cleared", rd, 32'h00);

    finish_run();
  end

endmodule